// File: doc/BRIEF.md
# Serial Management Frame Master

This block issues single register reads and writes to an external PHY over the two-wire serial management bus (MDC clock plus bidirectional MDIO data), following the Clause-22 frame layout. A host raises a one-cycle start with a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then produces the whole frame: it generates MDC, drives MDIO through a separate output-enable, and turns the line around for the PHY's reply.

A read ends with the 16 received data bits and an error flag. The flag is set when no PHY answered the turnaround. This case is caught because a pulled-up, undriven line returns a one where a present PHY drives a zero. The result is not passed on as all-ones data. A write ends with MDIO released. Either kind of transaction ends with a one-cycle done strobe. The host must wait for it, because the block ignores new commands while a frame is in progress.

Top module: `mdio_master`

## Requirements
- R1: Every transaction starts with 32 consecutive one bits on `mdio_o`, with `mdio_oe_o` high.
- R2: A read (`rd_i`=1) drives 14 header bits after the preamble, most significant first: `01`, `10`, PHY address[4:0], register address[4:0]. It then drops `mdio_oe_o` for the remaining 18 bit times, on the same clock edge on which `mdc_o` falls.
- R3: A read samples `mdio_i` on each rising edge of `mdc_o` during the last 18 bit times. Of these, the last 16 samples (MSB first) appear on `rdata_o` in the cycle `done_o` is high, and stay there until the next completion.
- R4: When the read sample taken just before the 16 data bits is 1, `err_o` is 1 and `rdata_o` is 0x0000. When that sample is 0, `err_o` is 0. A write always clears `err_o` and leaves `rdata_o` unchanged.
- R5: A write (`rd_i`=0) drives all 32 bits after the preamble, MSB first: `01`, `01`, PHY address, register address, `10`, write data[15:0].
- R6: `mdc_o` is low while idle. During a frame it toggles every HALF_DIV system clocks, starting low, for 64 full periods. The default HALF_DIV=40 gives a 400 ns period from a 5 ns clock.
- R7: During a frame, `mdio_o` changes only on the system clock edge on which `mdc_o` falls. The first bit appears on the edge that accepts the start.
- R8: `busy_o` rises on the edge that accepts `start_i` and falls with a one-cycle `done_o` pulse on the final MDC falling edge. A `start_i` seen while `busy_o` is high has no effect on the frame in progress.
- R9: Whenever `busy_o` is low, `mdio_oe_o` is low (MDIO released).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command, sampled when idle |
| rd_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Read got no turnaround response |
| rdata_o | output | 16 | Read data |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions check the following on every cycle:
- the data line holds still except on MDC falling edges;
- the output-enable drops only on a falling edge, and is off and MDC is low whenever the block is idle;
- `done_o` is a single cycle that ends `busy_o`;
- an error completion carries zero data.

Only the bench's scenarios can show that the frame bit content is right for given addresses and data, and that the sampled turnaround and data bits map to `err_o` and `rdata_o`. The same holds for an extra start in mid-frame changing nothing. The bench compares each of these cycle by cycle with a behavioural model of the frame and a PHY model.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned FRAME_W = 64;
  typedef logic [FRAME_W-1:0] frame_t;

  localparam logic [5:0] LAST_IDX    = 6'd63;
  localparam logic [5:0] RD_DRIVE    = 6'd46;  // bits driven by master on a read
  localparam logic [5:0] RD_CAP_FROM = 6'd47;  // turnaround low bit onwards

  localparam logic [1:0] SOF     = 2'b01;
  localparam logic [1:0] OP_RD   = 2'b10;
  localparam logic [1:0] OP_WR   = 2'b01;
  localparam logic [1:0] TA_WR   = 2'b10;

  typedef enum logic {ST_IDLE, ST_SHIFT} eng_state_e;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int unsigned HALF_DIV = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] TERM = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap = run_i && (cnt_q == TERM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = wrap & ~mdc_q;
  assign fall_o = wrap & mdc_q;
endmodule

// File: rtl/mdio_frame_fmt.sv
module mdio_frame_fmt
  import mdio_pkg::*;
(
  input  logic        rd_i,
  input  logic [4:0]  phy_addr_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [15:0] wdata_i,
  output frame_t      frame_o
);
  logic [31:0] body;

  always_comb begin
    if (rd_i) body = {SOF, OP_RD, phy_addr_i, reg_addr_i, 18'h0};
    else      body = {SOF, OP_WR, phy_addr_i, reg_addr_i, TA_WR, wdata_i};
  end

  // preamble built by replication
  assign frame_o = {{32{1'b1}}, body};
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        rd_i,
  input  frame_t      frame_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        busy_o,
  output logic        mdo_o,
  output logic        oe_o,
  output logic        done_o,
  output logic        err_o,
  output logic [15:0] rdata_o
);
  eng_state_e  state_q;
  frame_t      frame_q;
  logic [5:0]  idx_q;
  logic [5:0]  idx_nx;
  logic        rd_q;
  logic [16:0] cap_q;

  assign idx_nx = idx_q + 6'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      frame_q <= '0;
      idx_q   <= '0;
      rd_q    <= 1'b0;
      cap_q   <= '0;
      mdo_o   <= 1'b1;
      oe_o    <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SHIFT;
            frame_q <= frame_i;
            rd_q    <= rd_i;
            idx_q   <= '0;
            mdo_o   <= frame_i[FRAME_W-1];
            oe_o    <= 1'b1;
          end
        end
        ST_SHIFT: begin
          if (rise_i && rd_q && (idx_q >= RD_CAP_FROM))
            cap_q <= {cap_q[15:0], mdio_i};
          if (fall_i) begin
            if (idx_q == LAST_IDX) begin
              state_q <= ST_IDLE;
              oe_o    <= 1'b0;
              mdo_o   <= 1'b1;
              done_o  <= 1'b1;
              if (rd_q) begin
                err_o   <= cap_q[16];
                rdata_o <= cap_q[16] ? 16'h0 : cap_q[15:0];
              end else begin
                err_o <= 1'b0;
              end
            end else begin
              idx_q   <= idx_nx;
              frame_q <= frame_q << 1;
              mdo_o   <= frame_q[FRAME_W-2];
              oe_o    <= !rd_q || (idx_nx < RD_DRIVE);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == ST_SHIFT);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned HALF_DIV = 40
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        rd_i,
  input  logic [4:0]  phy_addr_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [15:0] wdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic [15:0] rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  frame_t frame;
  logic   rise, fall;

  mdio_frame_fmt u_fmt (
    .rd_i       (rd_i),
    .phy_addr_i (phy_addr_i),
    .reg_addr_i (reg_addr_i),
    .wdata_i    (wdata_i),
    .frame_o    (frame)
  );

  mdio_clk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_engine u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .rd_i    (rd_i),
    .frame_i (frame),
    .rise_i  (rise),
    .fall_i  (fall),
    .mdio_i  (mdio_i),
    .busy_o  (busy_o),
    .mdo_o   (mdio_o),
    .oe_o    (mdio_oe_o),
    .done_o  (done_o),
    .err_o   (err_o),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [15:0] rdata_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  p_mdo_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$fell(mdc_o)) |-> $stable(mdio_o));

  p_release_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $fell(mdio_oe_o)) |-> $fell(mdc_o));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_ends_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  p_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  p_idle_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdio_oe_o);

  p_mdc_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdc_o);

  p_err_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (rdata_o == 16'h0));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .rdata_o   (rdata_o),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int HD = 40;          // default divider
  localparam int TB = 128 * HD;    // frame length in system clocks

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rd = 1'b0;
  logic [4:0]  phy = '0;
  logic [4:0]  rga = '0;
  logic [15:0] wd = '0;
  logic        busy, done, err, mdc, mdo, oe;
  logic [15:0] rdata;
  logic        mdi = 1'b1;

  int total = 0;
  int bad = 0;
  logic [15:0] last_rdata = 16'h0;

  always #2.5 clk = ~clk;

  mdio_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rd_i(rd),
    .phy_addr_i(phy), .reg_addr_i(rga), .wdata_i(wd),
    .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
    .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(oe), .mdio_i(mdi)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // One transaction, compared against a behavioural frame model every cycle.
  task automatic run(input bit r, input logic [4:0] pa, input logic [4:0] ra,
                     input logic [15:0] d, input bit present,
                     input logic [15:0] pd, input int inject_t);
    logic [63:0] fr;
    logic [63:0] resp;
    fr = {32'hFFFF_FFFF, 2'b01, (r ? 2'b10 : 2'b01), pa, ra,
          (r ? 18'h0 : {2'b10, d})};
    // PHY reply for bit times 46..63: released bit (pull-up), zero, data
    resp = present ? {46'h0, 1'b1, 1'b0, pd} : {46'h0, 18'h3FFFF};
    @(negedge clk);
    start = 1'b1; rd = r; phy = pa; rga = ra; wd = d;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t <= TB; t++) begin
      int b;
      bit e_busy, e_mdc, e_oe;
      b = t / (2 * HD);
      e_busy = (t < TB);
      e_mdc  = (t < TB) && (((t / HD) % 2) == 1);
      e_oe   = (t < TB) && (!r || b < 46);
      chk(busy == e_busy, "R8", "busy", 32'(busy), 32'(e_busy));
      chk(mdc == e_mdc, "R6", "mdc", 32'(mdc), 32'(e_mdc));
      chk(oe == e_oe, r ? "R2" : "R9", "oe", 32'(oe), 32'(e_oe));
      if (e_oe) begin
        chk(mdo == fr[63-b], b < 32 ? "R1" : (r ? "R2" : "R5"),
            "mdio_o", 32'(mdo), 32'(fr[63-b]));
      end
      chk(done == (t == TB), "R8", "done", 32'(done), 32'(t == TB));
      if (t == TB) begin
        if (r) begin
          chk(err == !present, "R4", "err", 32'(err), 32'(!present));
          chk(rdata == (present ? pd : 16'h0), "R3", "rdata",
              32'(rdata), 32'(present ? pd : 16'h0));
          last_rdata = present ? pd : 16'h0;
        end else begin
          chk(err == 1'b0, "R4", "err after write", 32'(err), 32'h0);
          chk(rdata == last_rdata, "R4", "rdata kept", 32'(rdata), 32'(last_rdata));
        end
      end
      // stray start mid-frame with other fields (R8: must be ignored)
      if (t == inject_t) begin
        start = 1'b1; rd = ~r; phy = ~pa; rga = ~ra; wd = ~d;
      end else begin
        start = 1'b0;
      end
      if (oe) mdi = mdo;
      else if (t < TB && r && b >= 46) mdi = resp[63-b];
      else mdi = 1'b1;
      @(negedge clk);
    end
    chk(done == 1'b0, "R8", "done single pulse", 32'(done), 32'h0);
    chk(oe == 1'b0, "R9", "released after", 32'(oe), 32'h0);
    chk(rdata == last_rdata, "R3", "rdata held", 32'(rdata), 32'(last_rdata));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R8 watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R8", "reset idle", {busy, done}, 32'h0);
    chk(mdc == 0, "R6", "reset mdc", 32'(mdc), 32'h0);
    chk(oe == 0, "R9", "reset oe", 32'(oe), 32'h0);
    chk(err == 0 && rdata == 0, "R3", "reset result", {err, rdata}, 32'h0);

    run(1'b0, 5'h01, 5'h00, 16'hA5A5, 1'b1, 16'h0, -1);      // R5 write
    run(1'b0, 5'h1F, 5'h1F, 16'h0000, 1'b1, 16'h0, 1000);    // R5/R8 stray start
    run(1'b1, 5'h02, 5'h11, 16'h0, 1'b1, 16'h1234, -1);      // R3 read
    run(1'b1, 5'h1E, 5'h01, 16'h0, 1'b1, 16'hFFFF, 3000);    // R3 all-ones valid, R8
    run(1'b1, 5'h07, 5'h03, 16'h0, 1'b0, 16'h0, -1);         // R4 absent PHY
    run(1'b0, 5'h00, 5'h15, 16'h8001, 1'b1, 16'h0, -1);      // R4 write clears err
    run(1'b1, 5'h00, 5'h00, 16'h0, 1'b1, 16'h8001, -1);      // R3 boundary bits

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule